// File: doc/BRIEF.md
# Block-Floating-Point Shifter

This block shifts a 16-bit operand into a 32-bit registered field. It also measures how many redundant sign bits a value carries, normalizes values by that amount, and keeps a running minimum of those counts. A signal-processing datapath uses it to scale data between passes of a transform. Every value of an array goes through an exponent-detect operation, the block exponent then gives the common scale, and software issues shift operations with that scale. Two shifts with OR-merge build a 32-bit word from two 16-bit halves.

One operation is accepted per clock when `start` is high. Results appear on the registered outputs on the next rising edge. Software applies the signed count and handles any sequencing between fixed and floating representations.

Top module: `bfp_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0, `exp_out` becomes 0 and `blk_exp` becomes 15.
- R2: The operation codes are 00 shift, 01 normalize, 10 exponent detect and 11 reserved. When `start` is low, or the code is 11, `result` and `exp_out` keep their values.
- R3: The operand is placed in the field before it is shifted. With `hi_ref`=1 it goes into bits 31:16 and bits 15:0 are zero. With `hi_ref`=0 it goes into bits 15:0. Bits 31:16 are then zero when `arith`=0, or copies of operand bit 15 when `arith`=1.
- R4: A shift takes `shamt` as a 6-bit two's-complement count. A count of 0 to 31 shifts left with zero fill. A count of -1 to -31 shifts right. The outcome is in `result` one cycle after `start`.
- R5: A right shift fills with zeros when `arith`=0. When `arith`=1 it fills with copies of bit 31 of the placed field.
- R6: A count of -32 gives all zeros when `arith`=0. When `arith`=1 it gives 32 copies of bit 31 of the placed field.
- R7: When `merge`=1, a shift or a normalize ORs its new value into the previous `result` instead of replacing it.
- R8: Exponent detect sets `exp_out` to the number of bits below operand bit 15 that equal bit 15, counted down to the first bit that differs. The operand 0x0000 and the operand 0xFFFF both give 15. `result` is left unchanged.
- R9: Normalize shifts the placed field left by the detected exponent and also writes that exponent to `exp_out`. Take a non-trivial operand with `hi_ref`=1 and `merge`=0. After normalize, bit 31 of `result` differs from bit 30.
- R10: Each exponent-detect operation sets `blk_exp` to the smaller of its current value and the new exponent. Other operations leave `blk_exp` unchanged.
- R11: `blk_clr` resets `blk_exp` to 15. If an exponent-detect operation arrives in the same cycle, `blk_exp` takes that operation's exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe |
| op | input | 2 | Operation code |
| din | input | 16 | Operand |
| shamt | input | 6 | Signed shift count |
| arith | input | 1 | Arithmetic (sign) extension and fill |
| hi_ref | input | 1 | Place operand in the upper half |
| merge | input | 1 | OR the new value into the result |
| blk_clr | input | 1 | Clear the block exponent |
| result | output | 32 | Registered 32-bit field |
| exp_out | output | 4 | Registered detected exponent |
| blk_exp | output | 4 | Registered block exponent |

## Verification
The bench uses the default widths: a 16-bit operand, a 32-bit field and a 6-bit count. With a 6-bit count the extreme value -32 lies inside the legal range, so the saturating right shift is exercised directly, next to +31 and zero. A 16-bit operand keeps the trivial-value exponent of 15 and every intermediate exponent within reach of directed and random operands. A clear that coincides with an exponent detect is also reachable in a short run.

// File: rtl/bfp_shifter_pkg.sv
package bfp_shifter_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT  = 2'b00,
    OP_NORM   = 2'b01,
    OP_EXPDET = 2'b10,
    OP_RSVD   = 2'b11
  } shop_e;
endpackage

// File: rtl/bfp_expdet.sv
// Counts redundant sign bits of an operand (leading bits equal to the MSB).
module bfp_expdet #(
  parameter int DW = 16,
  parameter int EW = $clog2(DW)
) (
  input  logic [DW-1:0] val,
  output logic [EW-1:0] expo
);
  logic [DW-2:0] diff;

  genvar g;
  generate
    for (g = 0; g < DW-1; g++) begin : g_diff
      assign diff[g] = val[g] ^ val[DW-1];
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    expo  = EW'(DW-1);
    for (int i = DW-2; i >= 0; i--) begin
      if (!found && diff[i]) begin
        expo  = EW'(DW-2-i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfp_barrel.sv
// Logarithmic barrel shifter; magnitude of RW or more saturates to fill.
module bfp_barrel #(
  parameter int RW = 32,
  parameter int MW = $clog2(RW) + 1
) (
  input  logic [RW-1:0] fin,
  input  logic [MW-1:0] mag,
  input  logic          left,
  input  logic          fill,
  output logic [RW-1:0] fout
);
  localparam int SW = MW - 1;

  logic [RW-1:0] st [SW+1];

  assign st[0] = fin;

  genvar k;
  generate
    for (k = 0; k < SW; k++) begin : g_stage
      localparam int D = 1 << k;
      logic [RW-1:0] lsh;
      logic [RW-1:0] rsh;
      assign lsh = {st[k][RW-1-D:0], {D{1'b0}}};
      assign rsh = {{D{fill}}, st[k][RW-1:D]};
      assign st[k+1] = mag[k] ? (left ? lsh : rsh) : st[k];
    end
  endgenerate

  assign fout = mag[SW] ? {RW{~left & fill}} : st[SW];
endmodule

// File: rtl/bfp_blkexp.sv
// Running minimum of detected exponents with clear.
module bfp_blkexp #(
  parameter int EW   = 4,
  parameter int EMAX = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          upd,
  input  logic [EW-1:0] e_in,
  output logic [EW-1:0] blk
);
  logic [EW-1:0] base;
  logic [EW-1:0] nxt;

  always_comb begin
    base = clr ? EW'(EMAX) : blk;
    nxt  = (upd && (e_in < base)) ? e_in : base;
  end

  always_ff @(posedge clk) begin
    if (rst) blk <= EW'(EMAX);
    else     blk <= nxt;
  end
endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter #(
  parameter int DW = 16,
  parameter int RW = 2 * DW,
  parameter int CW = $clog2(RW) + 1,
  parameter int EW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] shamt,
  input  logic          arith,
  input  logic          hi_ref,
  input  logic          merge,
  input  logic          blk_clr,
  output logic [RW-1:0] result,
  output logic [EW-1:0] exp_out,
  output logic [EW-1:0] blk_exp
);
  import bfp_shifter_pkg::*;

  localparam int PADW = RW - DW;

  shop_e         opc;
  logic [RW-1:0] field;
  logic [EW-1:0] det_e;
  logic [CW-1:0] neg_cnt;
  logic [CW-1:0] mag;
  logic          go_left;
  logic          fill_bit;
  logic [RW-1:0] shifted;
  logic [RW-1:0] new_val;
  logic          wr_res;
  logic          wr_exp;

  assign opc = shop_e'(op);

  // operand placement
  always_comb begin
    if (hi_ref) field = {din, {PADW{1'b0}}};
    else        field = {{PADW{arith & din[DW-1]}}, din};
  end

  bfp_expdet #(.DW(DW), .EW(EW)) u_expdet (
    .val  (din),
    .expo (det_e)
  );

  // count decode: normalize uses detected exponent, shift uses signed count
  assign neg_cnt = (~shamt) + CW'(1);

  always_comb begin
    if (opc == OP_NORM) begin
      go_left = 1'b1;
      mag     = CW'(det_e);
    end else begin
      go_left = ~shamt[CW-1];
      mag     = shamt[CW-1] ? neg_cnt : shamt;
    end
    fill_bit = ~go_left & arith & field[RW-1];
  end

  bfp_barrel #(.RW(RW), .MW(CW)) u_barrel (
    .fin  (field),
    .mag  (mag),
    .left (go_left),
    .fill (fill_bit),
    .fout (shifted)
  );

  assign wr_res  = start && (opc == OP_SHIFT || opc == OP_NORM);
  assign wr_exp  = start && (opc == OP_NORM || opc == OP_EXPDET);
  assign new_val = merge ? (result | shifted) : shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      exp_out <= '0;
    end else begin
      if (wr_res) result  <= new_val;
      if (wr_exp) exp_out <= det_e;
    end
  end

  bfp_blkexp #(.EW(EW), .EMAX(DW-1)) u_blkexp (
    .clk  (clk),
    .rst  (rst),
    .clr  (blk_clr),
    .upd  (start && opc == OP_EXPDET),
    .e_in (det_e),
    .blk  (blk_exp)
  );
endmodule

// File: rtl/bfp_shifter_chk.sv
module bfp_shifter_chk #(
  parameter int DW = 16,
  parameter int RW = 2 * DW,
  parameter int CW = $clog2(RW) + 1,
  parameter int EW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    op,
  input logic [DW-1:0] din,
  input logic [CW-1:0] shamt,
  input logic          arith,
  input logic          hi_ref,
  input logic          merge,
  input logic          blk_clr,
  input logic [RW-1:0] result,
  input logic [EW-1:0] exp_out,
  input logic [EW-1:0] blk_exp
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && exp_out == '0 && blk_exp == EW'(DW-1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start || op == 2'b11) |=> ($stable(result) && $stable(exp_out)));

  // R6
  sat_right_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'b00 && !merge && shamt == {1'b1, {(CW-1){1'b0}}})
      |=> (result == '0 || result == '1));

  // R7
  merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (start && merge && (op == 2'b00 || op == 2'b01))
      |=> ((result & $past(result)) == $past(result)));

  // R8
  expdet_keeps_result_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'b10) |=> $stable(result));

  // R9
  norm_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'b01 && hi_ref && !merge && din != '0 && din != '1)
      |=> (result[RW-1] != result[RW-2]));

  // R10
  blk_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !blk_clr |=> (blk_exp <= $past(blk_exp)));

  // R11
  blk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_clr && !(start && op == 2'b10)) |=> (blk_exp == EW'(DW-1)));
endmodule

bind bfp_shifter bfp_shifter_chk #(.DW(DW), .RW(RW), .CW(CW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .din(din), .shamt(shamt),
  .arith(arith), .hi_ref(hi_ref), .merge(merge), .blk_clr(blk_clr),
  .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
);

// File: tb/bfp_shifter_bench.sv
`timescale 1ns/1ps
module bfp_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] din = '0;
  logic signed [5:0] shamt = '0;
  logic        arith = 1'b0, hi_ref = 1'b0, merge = 1'b0, blk_clr = 1'b0;
  logic [31:0] result;
  logic [3:0]  exp_out, blk_exp;

  int checks = 0, fails = 0;
  logic [31:0] m_res = '0;
  int m_exp = 0, m_blk = 15;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  bfp_shifter u_bfp_shifter (
    .clk(clk), .rst(rst), .start(start), .op(op), .din(din), .shamt(shamt),
    .arith(arith), .hi_ref(hi_ref), .merge(merge), .blk_clr(blk_clr),
    .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
  );

  function automatic int m_expo(logic [15:0] d);
    int e = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      e++;
    end
    return e;
  endfunction

  function automatic logic [31:0] m_place(logic [15:0] d, bit hi, bit ar);
    if (hi) return {d, 16'h0000};
    if (ar && d[15]) return 32'hFFFF0000 | 32'(d);
    return 32'(d);
  endfunction

  function automatic logic [31:0] m_shift(logic [31:0] p, int n, bit ar);
    int k;
    if (n >= 0) return p << n;
    k = -n;
    if (k >= 32) return (ar && p[31]) ? 32'hFFFFFFFF : 32'h0;
    if (ar) return 32'($signed(p) >>> k);
    return p >> k;
  endfunction

  task automatic check(string nm, longint act, longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, expv);
    end
  endtask

  // One cycle: check outputs of the previous op, then apply a new one.
  task automatic step(bit r, bit s, logic [1:0] o, logic [15:0] d,
                      logic signed [5:0] sh, bit ar, bit hi, bit mg, bit cl,
                      string t);
    logic [31:0] nv;
    int e, base;
    @(negedge clk);
    check("result", result, m_res);
    check("exp_out", exp_out, m_exp);
    check("blk_exp", blk_exp, m_blk);
    rst = r; start = s; op = o; din = d; shamt = sh;
    arith = ar; hi_ref = hi; merge = mg; blk_clr = cl; tag = t;
    if (r) begin
      m_res = '0; m_exp = 0; m_blk = 15;
    end else begin
      e = m_expo(d);
      base = cl ? 15 : m_blk;
      if (s) begin
        case (o)
          2'b00: begin
            nv = m_shift(m_place(d, hi, ar), int'(sh), ar);
            m_res = mg ? (m_res | nv) : nv;
          end
          2'b01: begin
            nv = m_place(d, hi, ar) << e;
            m_res = mg ? (m_res | nv) : nv;
            m_exp = e;
          end
          2'b10: begin
            m_exp = e;
            if (e < base) base = e;
          end
          default: ;
        endcase
      end
      m_blk = base;
    end
  endtask

  initial begin
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 2'b01, 16'h1234, 6'sd3, 1, 1, 1, 1, "R1");
    step(0, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0, "R1");
    step(0, 1, 2'b00, 16'h8421, 6'sd4, 0, 0, 0, 0, "R4");
    step(0, 1, 2'b00, 16'h8421, 6'sd31, 0, 0, 0, 0, "R4");
    step(0, 1, 2'b00, 16'h8421, 6'sd0, 1, 0, 0, 0, "R3");
    step(0, 1, 2'b00, 16'h8421, 6'sd0, 0, 1, 0, 0, "R3");
    step(0, 1, 2'b00, 16'h8421, -6'sd4, 1, 1, 0, 0, "R5");
    step(0, 1, 2'b00, 16'h8421, -6'sd4, 0, 1, 0, 0, "R5");
    step(0, 1, 2'b00, 16'h8421, -6'sd31, 1, 0, 0, 0, "R5");
    step(0, 1, 2'b00, 16'h8421, -6'sd32, 1, 1, 0, 0, "R6");
    step(0, 1, 2'b00, 16'h8421, -6'sd32, 0, 1, 0, 0, "R6");
    step(0, 1, 2'b00, 16'h7421, -6'sd32, 1, 1, 0, 0, "R6");
    step(0, 1, 2'b00, 16'hBEEF, 6'sd0, 0, 1, 0, 0, "R7");
    step(0, 1, 2'b00, 16'hCAFE, 6'sd0, 0, 0, 1, 0, "R7");
    step(0, 0, 2'b00, 16'h0001, 6'sd5, 0, 0, 0, 0, "R2");
    step(0, 1, 2'b11, 16'h0001, 6'sd5, 0, 0, 0, 0, "R2");
    step(0, 1, 2'b10, 16'h0000, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 2'b10, 16'hFFFF, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 2'b10, 16'h0001, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 2'b10, 16'hC000, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 2'b10, 16'h0F00, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 2'b10, 16'h8000, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 2'b10, 16'h8000, 0, 0, 0, 0, 1, "R11");
    step(0, 1, 2'b10, 16'h0040, 0, 0, 0, 0, 1, "R11");
    step(0, 1, 2'b01, 16'h0040, 0, 0, 1, 0, 0, "R9");
    step(0, 1, 2'b01, 16'hFFF3, 0, 1, 0, 0, 0, "R9");
    step(0, 1, 2'b01, 16'h0000, 0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 600; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      case ($urandom % 4)
        0: d = d >> ($urandom % 16);
        1: d = ~(16'hFFFF >> ($urandom % 17)) | (d >> 12);
        default: ;
      endcase
      step(0, ($urandom % 10) != 0, 2'($urandom), d, 6'($urandom),
           1'($urandom), 1'($urandom), ($urandom % 4) == 0,
           ($urandom % 10) == 0, "R4");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule